// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits between a simple host request port and a byte-wide asynchronous parallel NOR flash. The host asks for one operation at a time: chip erase, sector erase, block erase, byte program, write-protect or write-unprotect. The sequencer then drives the ordered list of unlock and command writes to the magic offsets, holding write-enable low for a set number of clocks on each cycle. Erase frames get a long programmable spacing between cycles.

After the command writes, erase and program operations wait for the flash to finish. The block issues repeated status reads at the request address and compares bit 6 of each read with the previous one. When two reads in a row agree, the operation is complete. If that bit keeps changing for a parameterised number of comparisons, the block gives up and flags an error with done. Unprotect ends with a fixed settle wait instead of polling. Protect ends as soon as its writes are out.

`busy` stays high from acceptance until the one-cycle `done` pulse. Requests that arrive while the block is busy are dropped.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `busy`, `done` and `err` are low and both `flash_we_n` and `flash_oe_n` are high.
- R2: `req_op` codes are 0 chip erase, 1 sector erase, 2 block erase, 3 byte program, 4 protect and 5 unprotect. Chip erase writes, in order: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x10@0x5555.
- R3: Sector erase and block erase use the chip-erase frame, except that the sixth write goes to the request address and carries 0x30 (sector) or 0x50 (block).
- R4: Byte program writes 0xAA@0x5555, 0x55@0x2AAA, 0xA0@0x5555 and then the request data at the request address, and then polls. Protect writes only the first three of those and issues no reads.
- R5: Unprotect writes the chip-erase frame with 0x20@0x5555 as its sixth write. It then waits SETTLE_CYCLES clocks with no bus activity before `done`, and issues no reads.
- R6: Each write holds `flash_we_n` low for WE_CYCLES clocks. It is followed by GAP_CYCLES idle clocks for the three erase operations, or 1 idle clock for the others. Each status read holds `flash_oe_n` low for RD_CYCLES clocks, with 1 idle clock between reads.
- R7: Erase and program operations issue status reads at the request address. They complete without error on the first read whose bit 6 equals bit 6 of the previous read.
- R8: If MAX_POLLS successive comparisons all find bit 6 changed, the block raises `done` together with `err` after MAX_POLLS+1 reads. A match on exactly the MAX_POLLS-th comparison is a success.
- R9: `busy` goes high on the clock after a legal request is accepted and stays high through the `done` cycle. A request seen while `busy` is high is ignored.
- R10: A request with `req_op` 6 or 7 is ignored: no bus cycle, no `busy`, no `done`.
- R11: `done` is a single-cycle pulse, and `flash_we_n` and `flash_oe_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_op | input | 3 | Operation code (see R2) |
| req_addr | input | AW | Target address for sector/block/program and status reads |
| req_data | input | 8 | Byte to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Poll timeout, valid with done |
| flash_addr | output | AW | Flash address bus |
| flash_dout | output | 8 | Flash write data |
| flash_din | input | 8 | Flash read data |
| flash_we_n | output | 1 | Flash write enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |

## Verification
Each operation's `done` timing follows directly from R6. `done` is due N*(WE_CYCLES+gap) clocks after the accepting edge, where N is the write count. Polled operations add K*(RD_CYCLES+1)-1 clocks, where K is the read count, and unprotect adds SETTLE_CYCLES. The bench computes this figure for every request and counts negative edges from the accepting edge until `done`, so an early or late completion shows up as a latency mismatch. Write and read cycles are logged on the edge after the strobe falls. Outputs are sampled on the falling edge, away from the edges where the design updates.

// File: rtl/fseq_pkg.sv
// Shared types, command bytes and per-operation properties for the
// parallel flash command sequencer. Assumes a byte-wide flash.
package fseq_pkg;

    localparam int DW = 8;

    typedef enum logic [2:0] {
        OP_CHIP_ERASE = 3'd0,
        OP_SECT_ERASE = 3'd1,
        OP_BLK_ERASE  = 3'd2,
        OP_PROGRAM    = 3'd3,
        OP_LOCK       = 3'd4,
        OP_UNLOCK     = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_WR, S_GAP, S_RD, S_RGAP, S_SETTLE, S_DONE
    } st_e;

    localparam logic [15:0] KEY_ADDR_A = 16'h5555;
    localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  KEY_BYTE_A = 8'hAA;
    localparam logic [7:0]  KEY_BYTE_B = 8'h55;
    localparam logic [7:0]  CMD_SETUP  = 8'h80;
    localparam logic [7:0]  CMD_CHIP   = 8'h10;
    localparam logic [7:0]  CMD_SECT   = 8'h30;
    localparam logic [7:0]  CMD_BLK    = 8'h50;
    localparam logic [7:0]  CMD_PROG   = 8'hA0;
    localparam logic [7:0]  CMD_OPEN   = 8'h20;

    // Legal operation code check
    function automatic logic op_legal(input logic [2:0] code);
        return code <= 3'd5;
    endfunction

    // Index of the final write in an operation's frame
    function automatic logic [2:0] last_idx(input op_e op);
        case (op)
            OP_PROGRAM: return 3'd3;
            OP_LOCK:    return 3'd2;
            default:    return 3'd5;
        endcase
    endfunction

    // Erase frames take the long inter-cycle spacing
    function automatic logic is_spaced(input op_e op);
        return (op == OP_CHIP_ERASE) || (op == OP_SECT_ERASE) || (op == OP_BLK_ERASE);
    endfunction

    // Operations that wait on the toggling status bit
    function automatic logic is_polled(input op_e op);
        return is_spaced(op) || (op == OP_PROGRAM);
    endfunction

    // Largest of four delay parameters, sizes the shared timer
    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/fseq_step_gen.sv
// Maps (operation, write index) to the address and data of that write
// cycle, and flags the last write of the frame. Purely combinational.
// Assumes AW is at least 16 so the key offsets fit.
module fseq_step_gen
    import fseq_pkg::*;
#(
    parameter int AW = 19
) (
    input  op_e            op,
    input  logic [2:0]     idx,
    input  logic [AW-1:0]  tgt_addr,
    input  logic [DW-1:0]  tgt_data,
    output logic [AW-1:0]  s_addr,
    output logic [DW-1:0]  s_data,
    output logic           s_last
);
    localparam logic [AW-1:0] KA = AW'(KEY_ADDR_A);
    localparam logic [AW-1:0] KB = AW'(KEY_ADDR_B);

    // Select the write for the current position in the frame
    always_comb begin
        s_addr = KA;
        s_data = KEY_BYTE_A;
        case (idx)
            3'd0: begin
                s_addr = KA;
                s_data = KEY_BYTE_A;
            end
            3'd1, 3'd4: begin
                s_addr = KB;
                s_data = KEY_BYTE_B;
            end
            3'd2: begin
                s_addr = KA;
                s_data = (op == OP_PROGRAM || op == OP_LOCK) ? CMD_PROG : CMD_SETUP;
            end
            3'd3: begin
                if (op == OP_PROGRAM) begin
                    s_addr = tgt_addr;
                    s_data = tgt_data;
                end else begin
                    s_addr = KA;
                    s_data = KEY_BYTE_A;
                end
            end
            default: begin
                case (op)
                    OP_CHIP_ERASE: begin s_addr = KA;       s_data = CMD_CHIP; end
                    OP_SECT_ERASE: begin s_addr = tgt_addr; s_data = CMD_SECT; end
                    OP_BLK_ERASE:  begin s_addr = tgt_addr; s_data = CMD_BLK;  end
                    default:       begin s_addr = KA;       s_data = CMD_OPEN; end
                endcase
            end
        endcase
    end

    // Last write of the frame for this operation
    assign s_last = (idx == last_idx(op));

endmodule

// File: rtl/fseq_delay.sv
// Loadable down-counter used for write pulses, spacing, read pulses and
// the settle wait. zero is high once the loaded count has run out.
module fseq_delay #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt;

    // Load on request, otherwise count down to zero and hold
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (load)           cnt <= load_val;
        else if (cnt != '0)      cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/fseq_toggle.sv
// Toggle-bit completion detector. It keeps the previous sample of the
// status bit and counts comparisons that found the bit changed.
// match/timeout are valid in the cycle a sample is offered.
module fseq_toggle #(
    parameter int MAX_POLLS = 32'h0FFF_FFFF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sample,
    input  logic bit_in,
    output logic match,
    output logic timeout
);
    localparam int CW = $clog2(MAX_POLLS + 1);

    logic          have_prev;
    logic          prev;
    logic [CW-1:0] nmis;
    logic          same;

    assign same    = have_prev && (bit_in == prev);
    assign match   = sample && same;
    assign timeout = sample && have_prev && !same && (nmis == CW'(MAX_POLLS - 1));

    // Track the last sample and the number of mismatching comparisons
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            have_prev <= 1'b0;
            prev      <= 1'b0;
            nmis      <= '0;
        end else if (sample) begin
            have_prev <= 1'b1;
            prev      <= bit_in;
            if (have_prev && !same) nmis <= nmis + 1'b1;
        end
    end

endmodule

// File: rtl/flash_cmd_seq.sv
// Parallel NOR flash command sequencer. It accepts one operation while
// idle, plays its unlock/command frame on the flash bus, and then polls
// the toggle bit, waits a settle time, or finishes at once, depending on
// the operation. Assumes the flash samples data while flash_we_n is low
// and drives flash_din while flash_oe_n is low. All delays are in clocks
// and must be at least 1.
module flash_cmd_seq
    import fseq_pkg::*;
#(
    parameter int AW            = 19,
    parameter int WE_CYCLES     = 4,
    parameter int GAP_CYCLES    = 500,
    parameter int SETTLE_CYCLES = 10000,
    parameter int RD_CYCLES     = 4,
    parameter int MAX_POLLS     = 32'h0FFF_FFFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [AW-1:0] flash_addr,
    output logic [7:0]    flash_dout,
    input  logic [7:0]    flash_din,
    output logic          flash_we_n,
    output logic          flash_oe_n
);
    localparam int DMAX = max4(WE_CYCLES, GAP_CYCLES, SETTLE_CYCLES, RD_CYCLES);
    localparam int TW   = $clog2(DMAX + 1) + 1;
    localparam logic [TW-1:0] LD_WE  = TW'(WE_CYCLES - 1);
    localparam logic [TW-1:0] LD_GAP = TW'(GAP_CYCLES - 1);
    localparam logic [TW-1:0] LD_SET = TW'(SETTLE_CYCLES - 1);
    localparam logic [TW-1:0] LD_RD  = TW'(RD_CYCLES - 1);

    st_e           st, st_n;
    op_e           op_q;
    logic [AW-1:0] addr_q;
    logic [7:0]    data_q;
    logic [2:0]    idx, idx_n;
    logic          err_q;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;

    logic [AW-1:0] s_addr;
    logic [7:0]    s_data;
    logic          s_last;

    logic          accept;
    logic          poll_sample;
    logic          poll_match;
    logic          poll_tmo;
    logic          unused_din;

    assign accept      = (st == S_IDLE) && req_valid && op_legal(req_op);
    assign poll_sample = (st == S_RD) && tmr_zero;
    assign unused_din  = ^{flash_din[7], flash_din[5:0]};

    fseq_step_gen #(.AW(AW)) u_step (
        .op       (op_q),
        .idx      (idx),
        .tgt_addr (addr_q),
        .tgt_data (data_q),
        .s_addr   (s_addr),
        .s_data   (s_data),
        .s_last   (s_last)
    );

    fseq_delay #(.TW(TW)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    fseq_toggle #(.MAX_POLLS(MAX_POLLS)) u_toggle (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .sample  (poll_sample),
        .bit_in  (flash_din[6]),
        .match   (poll_match),
        .timeout (poll_tmo)
    );

    // Next-state, write index and timer reload decisions
    always_comb begin
        st_n     = st;
        idx_n    = idx;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (st)
            S_IDLE: begin
                if (accept) begin
                    st_n     = S_WR;
                    idx_n    = 3'd0;
                    tmr_load = 1'b1;
                    tmr_val  = LD_WE;
                end
            end
            S_WR: begin
                if (tmr_zero) begin
                    st_n     = S_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = is_spaced(op_q) ? LD_GAP : '0;
                end
            end
            S_GAP: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (!s_last) begin
                        st_n    = S_WR;
                        idx_n   = idx + 3'd1;
                        tmr_val = LD_WE;
                    end else if (is_polled(op_q)) begin
                        st_n    = S_RD;
                        tmr_val = LD_RD;
                    end else if (op_q == OP_UNLOCK) begin
                        st_n    = S_SETTLE;
                        tmr_val = LD_SET;
                    end else begin
                        st_n    = S_DONE;
                    end
                end
            end
            S_RD: begin
                if (tmr_zero) begin
                    st_n = (poll_match || poll_tmo) ? S_DONE : S_RGAP;
                end
            end
            S_RGAP: begin
                st_n     = S_RD;
                tmr_load = 1'b1;
                tmr_val  = LD_RD;
            end
            S_SETTLE: begin
                if (tmr_zero) st_n = S_DONE;
            end
            default: st_n = S_IDLE;
        endcase
    end

    // State and write index registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= S_IDLE;
            idx <= 3'd0;
        end else begin
            st  <= st_n;
            idx <= idx_n;
        end
    end

    // Capture the accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_CHIP_ERASE;
            addr_q <= '0;
            data_q <= '0;
        end else if (accept) begin
            op_q   <= op_e'(req_op);
            addr_q <= req_addr;
            data_q <= req_data;
        end
    end

    // Timeout flag, cleared on acceptance and set when the poll gives up
    always_ff @(posedge clk) begin
        if (!rst_n || accept) err_q <= 1'b0;
        else if (poll_tmo)    err_q <= 1'b1;
    end

    // Bus and host outputs, decoded from the registered state
    always_comb begin
        flash_we_n = (st != S_WR);
        flash_oe_n = (st != S_RD);
        flash_addr = '0;
        flash_dout = '0;
        if (st == S_WR || st == S_GAP) begin
            flash_addr = s_addr;
            flash_dout = s_data;
        end else if (st == S_RD || st == S_RGAP) begin
            flash_addr = addr_q;
        end
        busy = (st != S_IDLE);
        done = (st == S_DONE);
        err  = (st == S_DONE) && err_q;
    end

endmodule

// File: rtl/fseq_checker.sv
// Protocol checker for flash_cmd_seq, attached with bind. It observes
// only ports.
module fseq_checker #(
    parameter int AW = 19
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [2:0]    req_op,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic          flash_we_n,
    input logic          flash_oe_n,
    input logic [AW-1:0] flash_addr
);
    // Write and read strobes never overlap
    p_bus_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!flash_we_n && !flash_oe_n));

    // done lasts a single cycle
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // busy covers the done cycle
    p_busy_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // busy does not drop before done
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // Legal request from idle starts the first write at once
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_op <= 3'd5) |=> (busy && !flash_we_n));

    // Illegal code leaves the block idle
    p_bad_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_op > 3'd5) |=> !busy);

    // A timeout error is only reported right after a status read
    p_err_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(!flash_oe_n));

    // No bus activity while idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (flash_we_n && flash_oe_n && flash_addr == '0));

endmodule

bind flash_cmd_seq fseq_checker #(.AW(AW)) u_fseq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .flash_we_n (flash_we_n),
    .flash_oe_n (flash_oe_n),
    .flash_addr (flash_addr)
);

// File: tb/flash_cmd_seq_bench.sv
// Directed bench for flash_cmd_seq with a small flash responder whose
// status bit 6 flips on a chosen number of reads.
module flash_cmd_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 19;
    localparam int WE   = 2;
    localparam int GAP  = 5;
    localparam int SET  = 20;
    localparam int RDC  = 2;
    localparam int MAXP = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = 3'd0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic          busy, done, err;
    logic [AW-1:0] flash_addr;
    logic [7:0]    flash_dout;
    logic [7:0]    flash_din;
    logic          flash_we_n, flash_oe_n;

    int checks = 0;
    int errors = 0;

    // Responder state
    logic          we_q, oe_q, tbit;
    int            wn, rn;
    int            rn_base = 0;
    int            tog_set = 0;
    logic [AW-1:0] wa [0:255];
    logic [7:0]    wd [0:255];
    logic [AW-1:0] ra_last;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_seq #(
        .AW(AW), .WE_CYCLES(WE), .GAP_CYCLES(GAP), .SETTLE_CYCLES(SET),
        .RD_CYCLES(RDC), .MAX_POLLS(MAXP)
    ) u_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
        .err(err), .flash_addr(flash_addr), .flash_dout(flash_dout),
        .flash_din(flash_din), .flash_we_n(flash_we_n), .flash_oe_n(flash_oe_n)
    );

    assign flash_din = {1'b1, tbit, 6'h15};

    // Log each write and read at its start; flip the status bit on busy reads
    always @(posedge clk) begin
        if (!rst_n) begin
            we_q <= 1'b1; oe_q <= 1'b1; tbit <= 1'b0; wn <= 0; rn <= 0;
            ra_last <= '0;
        end else begin
            we_q <= flash_we_n;
            oe_q <= flash_oe_n;
            if (we_q && !flash_we_n && wn < 256) begin
                wa[wn] <= flash_addr;
                wd[wn] <= flash_dout;
                wn <= wn + 1;
            end
            if (oe_q && !flash_oe_n) begin
                if (rn - rn_base < tog_set) tbit <= ~tbit;
                ra_last <= flash_addr;
                rn <= rn + 1;
            end
        end
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Expected write i of an operation, taken from R2..R5
    task automatic exp_w(input int op, input int i, input logic [AW-1:0] a,
                         input logic [7:0] d, output logic [AW-1:0] ea,
                         output logic [7:0] ed);
        ea = AW'(16'h5555); ed = 8'hAA;
        case (i)
            1, 4: begin ea = AW'(16'h2AAA); ed = 8'h55; end
            2:    ed = (op == 3 || op == 4) ? 8'hA0 : 8'h80;
            3:    if (op == 3) begin ea = a; ed = d; end
            5: begin
                case (op)
                    0: ed = 8'h10;
                    1: begin ea = a; ed = 8'h30; end
                    2: begin ea = a; ed = 8'h50; end
                    default: ed = 8'h20;
                endcase
            end
            default: ;
        endcase
    endtask

    // One operation: latency, error flag, write list and read count
    task automatic run_op(input int op, input logic [AW-1:0] a, input logic [7:0] d,
                          input int togs, input bit intrude, input string rq);
        int nw, g, k, m, lat, n, wb, rb;
        bit pol, e_err;
        logic [AW-1:0] ea;
        logic [7:0] ed;
        nw  = (op == 3) ? 4 : (op == 4) ? 3 : 6;
        g   = (op <= 2) ? GAP : 1;
        pol = (op <= 3);
        k = 0; e_err = 0;
        if (pol) begin
            m = (togs < 1) ? 1 : togs;
            if (m > MAXP) begin k = MAXP + 1; e_err = 1; end
            else k = m + 1;
        end
        lat = nw * (WE + g) + (pol ? k * (RDC + 1) - 1 : 0) + (op == 5 ? SET : 0);
        wb = wn; rb = rn; rn_base = rn; tog_set = togs;
        @(negedge clk);
        req_valid = 1'b1; req_op = op[2:0]; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (intrude) req_op = 3'd4;
        n = 0;
        check(busy === 1'b1, "R9", "busy after accept", busy, 1);
        while (done !== 1'b1 && n < 4000) begin
            if (intrude) req_valid = (n >= 3 && n < 6);
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        check(n == lat, "R6", {rq, " done latency"}, n, lat);
        check(err === e_err, (e_err ? "R8" : "R7"), {rq, " err flag"}, err, e_err);
        check(busy === 1'b1, "R9", "busy in done cycle", busy, 1);
        @(negedge clk);
        check(done === 1'b0, "R11", "done pulse width", done, 0);
        check(busy === 1'b0, "R9", "busy after done", busy, 0);
        check(wn - wb == nw, rq, "write count", wn - wb, nw);
        for (int i = 0; i < nw; i++) begin
            exp_w(op, i, a, d, ea, ed);
            check(wa[wb + i] === ea, rq, $sformatf("write %0d addr", i), wa[wb + i], ea);
            check(wd[wb + i] === ed, rq, $sformatf("write %0d data", i), wd[wb + i], ed);
        end
        check(rn - rb == k, (pol ? "R7" : "R4"), {rq, " read count"}, rn - rb, k);
        if (k > 0) check(ra_last === a, "R7", "read address", ra_last, a);
    endtask

    // Illegal operation code: nothing may happen
    task automatic bad_op(input logic [2:0] code);
        int wb;
        wb = wn;
        @(negedge clk);
        req_valid = 1'b1; req_op = code;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 8; i++) begin
            check(busy === 1'b0 && done === 1'b0, "R10", "idle after bad code", busy, 0);
            @(negedge clk);
        end
        check(wn == wb && flash_oe_n === 1'b1, "R10", "no bus cycle", wn - wb, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R1", "host outputs", busy, 0);
        check(flash_we_n === 1'b1 && flash_oe_n === 1'b1, "R1", "strobes", flash_we_n, 1);

        run_op(0, '0,          8'h00, 3,  1'b0, "R2");
        run_op(1, 19'h12000,   8'h00, 0,  1'b0, "R3");
        run_op(2, 19'h40000,   8'h00, 5,  1'b0, "R3");
        run_op(3, 19'h00ABC,   8'h3C, 2,  1'b0, "R4");
        run_op(4, '0,          8'h00, 0,  1'b0, "R4");
        run_op(5, '0,          8'h00, 0,  1'b0, "R5");
        run_op(3, 19'h00100,   8'h5A, 16, 1'b0, "R8");
        run_op(0, 19'h00007,   8'h00, 17, 1'b0, "R8");
        run_op(0, '0,          8'h00, 1,  1'b1, "R9");
        bad_op(3'd6);
        bad_op(3'd7);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule